// File: doc/BRIEF.md
# Bus Turnaround Response Timeout Monitor

This block measures the quiet gap on a serial bus between the end of a packet that the local side sent and the start of the packet that comes back. The timer starts on the local transmitter's end-of-packet-to-idle edge and stops when the far side's start-of-packet is seen. It counts in half-bit units, using a clock enable that pulses once per half bit time. Counting in half bits lets the 7.5-bit device reply budget be compared exactly.

Two windows are checked. The first is a 16-bit-time wait limit (32 half bits) for the transmitter. If no reply has begun by the end of that limit, the monitor raises a one-cycle timeout pulse and returns to idle. A receiver that finds errors in a packet stays silent, so a timeout tells the sender that its packet was corrupted or lost. The second is a 7.5-bit-time device budget (15 half bits). A separate pulse warns as soon as the gap grows past that budget.

When a reply arrives in time, the monitor gives a response pulse and the measured gap. The gap is held until the next arm. Parameters describe the number of hub tiers and the delay of each tier. An elaboration check refuses any setting in which the worst-case round trip plus the device budget would no longer fit inside the wait limit.

Top module: `turnaround_monitor`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, `resp_seen`, `timeout` and `budget_miss` are 0 and `gap` is 0.
- R2: A cycle with `tx_eop_idle` high arms the monitor and clears the count to 0. A later `rx_sop` cycle while armed gives `resp_seen` high for exactly one cycle. With it, `gap` equals the number of `half_bit_en` cycles strictly between the arming cycle and the `rx_sop` cycle. The monitor is then idle.
- R3: A reply whose gap is 17 to 32 half bits is still accepted: `resp_seen` pulses with that gap and `timeout` stays 0.
- R4: If a 33rd `half_bit_en` cycle occurs while armed with no `rx_sop`, `timeout` is high for exactly one cycle and the monitor goes idle. `timeout` and `resp_seen` are never high together.
- R5: `rx_sop` while the monitor is idle produces no `resp_seen` and leaves `gap` unchanged. This includes a reply that comes after a timeout.
- R6: `tx_eop_idle` while already armed restarts the count from 0 and clears `gap` to 0.
- R7: `budget_miss` pulses for exactly one cycle on the 16th counted `half_bit_en` cycle, as the gap passes 15 half bits. It does not pulse when a reply arrives with a gap of 15 or less.
- R8: `gap` holds its value from a response until the next `tx_eop_idle` or reset.
- R9: If `tx_eop_idle` and `rx_sop` are high in the same cycle, arming wins and the `rx_sop` is ignored.
- R10: If `rx_sop` and `half_bit_en` are high in the same cycle, the reply is taken at the current count and that half bit is not counted. At a count of 32 this gives `resp_seen` with `gap` 32 and no `timeout`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| half_bit_en | input | 1 | One pulse per half bit time |
| tx_eop_idle | input | 1 | Local transmit end-of-packet-to-idle edge, one cycle |
| rx_sop | input | 1 | Start-of-packet seen from the far side, one cycle |
| resp_seen | output | 1 | One-cycle pulse: a reply arrived within the limit |
| timeout | output | 1 | One-cycle pulse: the wait limit expired |
| budget_miss | output | 1 | One-cycle pulse: the gap passed the device reply budget |
| gap | output | 6 | Measured gap in half bits, held until the next arm |

## Verification
Every output is a register. An input sampled at one rising edge therefore shows up on `resp_seen`, `timeout`, `budget_miss` or `gap` just after that same edge, with no further delay. The bench drives inputs on the falling edge and checks all four outputs 1 ns after the next rising edge, in every cycle it steps. The sweep runs every tick count from 0 to 34, both with ticks back to back and with idle cycles between them. The expected pulse in each cycle comes from a count the bench keeps itself.

// File: rtl/tam_pkg.sv
package tam_pkg;

    typedef enum logic {
        TAM_IDLE  = 1'b0,
        TAM_ARMED = 1'b1
    } tam_state_e;

    typedef struct packed {
        tam_state_e state;
        logic       resp_seen;
        logic       timeout;
        logic       budget_miss;
    } tam_ctrl_t;

endpackage

// File: rtl/tam_halfbit_counter.sv
module tam_halfbit_counter #(
    parameter int CNT_W    = 6,
    parameter int LIMIT_HB = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             advance,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] LIMIT_C = CNT_W'(LIMIT_HB);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clear)
            cnt_d = '0;
        else if (advance && cnt_q != LIMIT_C)
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LIMIT_C);                                   // R4

endmodule

// File: rtl/tam_window_check.sv
module tam_window_check #(
    parameter int CNT_W     = 6,
    parameter int LIMIT_HB  = 32,
    parameter int BUDGET_HB = 15
) (
    input  logic [CNT_W-1:0] cnt,
    output logic             at_limit,
    output logic             at_budget
);
    localparam logic [CNT_W-1:0] LIMIT_C  = CNT_W'(LIMIT_HB);
    localparam logic [CNT_W-1:0] BUDGET_C = CNT_W'(BUDGET_HB);

    always_comb begin
        at_limit  = (cnt == LIMIT_C);
        at_budget = (cnt == BUDGET_C);
    end

endmodule

// File: rtl/tam_gap_hold.sv
module tam_gap_hold #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             capture,
    input  logic [CNT_W-1:0] value,
    output logic [CNT_W-1:0] gap
);
    logic [CNT_W-1:0] gap_d, gap_q;

    always_comb begin
        gap_d = gap_q;
        if (clear)
            gap_d = '0;
        else if (capture)
            gap_d = value;
    end

    always_ff @(posedge clk) begin
        if (rst) gap_q <= '0;
        else     gap_q <= gap_d;
    end

    assign gap = gap_q;

endmodule

// File: rtl/turnaround_monitor.sv
module turnaround_monitor #(
    parameter int TX_LIMIT_HB   = 32,
    parameter int DEV_BUDGET_HB = 15,
    parameter int TIER_COUNT    = 5,
    parameter int TIER_DELAY_NS = 70,
    parameter int HALF_BIT_PS   = 41667,
    localparam int GAP_W        = $clog2(TX_LIMIT_HB + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             half_bit_en,
    input  logic             tx_eop_idle,
    input  logic             rx_sop,
    output logic             resp_seen,
    output logic             timeout,
    output logic             budget_miss,
    output logic [GAP_W-1:0] gap
);
    import tam_pkg::*;

    localparam int  RT_PS     = 2 * TIER_COUNT * TIER_DELAY_NS * 1000;
    localparam int  RT_HB     = (RT_PS + HALF_BIT_PS - 1) / HALF_BIT_PS;
    localparam bit  TIER_FIT  = (RT_HB + DEV_BUDGET_HB) <= TX_LIMIT_HB;
    localparam logic [GAP_W-1:0] LIMIT_C = GAP_W'(TX_LIMIT_HB);

    if (!TIER_FIT) begin : g_tier_overflow
        $error("tier delay plus device budget exceeds the wait limit");
    end

    tam_ctrl_t        ctrl_d, ctrl_q;
    logic [GAP_W-1:0] cnt;
    logic             at_limit, at_budget;
    logic             armed, arm, hit, tick;

    always_comb begin
        armed  = (ctrl_q.state == TAM_ARMED);
        arm    = tx_eop_idle;
        hit    = armed && rx_sop && !arm;
        tick   = armed && half_bit_en && !rx_sop && !arm;

        ctrl_d             = ctrl_q;
        ctrl_d.resp_seen   = 1'b0;
        ctrl_d.timeout     = 1'b0;
        ctrl_d.budget_miss = tick && at_budget;
        if (arm) begin
            ctrl_d.state = TAM_ARMED;
        end else if (hit) begin
            ctrl_d.state     = TAM_IDLE;
            ctrl_d.resp_seen = 1'b1;
        end else if (tick && at_limit) begin
            ctrl_d.state   = TAM_IDLE;
            ctrl_d.timeout = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) ctrl_q <= '{state: TAM_IDLE, default: 1'b0};
        else     ctrl_q <= ctrl_d;
    end

    tam_halfbit_counter #(.CNT_W(GAP_W), .LIMIT_HB(TX_LIMIT_HB)) u_counter (
        .clk     (clk),
        .rst     (rst),
        .clear   (arm),
        .advance (tick),
        .cnt     (cnt)
    );

    tam_window_check #(.CNT_W(GAP_W), .LIMIT_HB(TX_LIMIT_HB),
                       .BUDGET_HB(DEV_BUDGET_HB)) u_window (
        .cnt       (cnt),
        .at_limit  (at_limit),
        .at_budget (at_budget)
    );

    tam_gap_hold #(.CNT_W(GAP_W)) u_gap (
        .clk     (clk),
        .rst     (rst),
        .clear   (arm),
        .capture (hit),
        .value   (cnt),
        .gap     (gap)
    );

    assign resp_seen   = ctrl_q.resp_seen;
    assign timeout     = ctrl_q.timeout;
    assign budget_miss = ctrl_q.budget_miss;

    AST_GAP_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        resp_seen |-> gap <= LIMIT_C);                       // R3
    AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (rst)
        $onehot0({resp_seen, timeout}));                     // R4
    AST_TIMEOUT_SINGLE: assert property (@(posedge clk) disable iff (rst)
        timeout |=> !timeout);                               // R4
    AST_IDLE_SOP_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (!armed && rx_sop && !tx_eop_idle) |=> !resp_seen);  // R5
    AST_BUDGET_SINGLE: assert property (@(posedge clk) disable iff (rst)
        budget_miss |=> !budget_miss);                       // R7
    AST_GAP_HELD: assert property (@(posedge clk) disable iff (rst)
        (!resp_seen && !$past(tx_eop_idle) && !$past(rst)) |-> $stable(gap)); // R8

endmodule

// File: tb/tb_turnaround_monitor.sv
module tb_turnaround_monitor;

    localparam int LIMIT  = 32;
    localparam int BUDGET = 15;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       half_bit_en = 1'b0;
    logic       tx_eop_idle = 1'b0;
    logic       rx_sop = 1'b0;
    logic       resp_seen, timeout, budget_miss;
    logic [5:0] gap;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    int  exp_gap = 0;
    bit  m_armed = 1'b0;
    int  m_cnt   = 0;

    always #10 clk = ~clk;

    turnaround_monitor dut (
        .clk         (clk),
        .rst         (rst),
        .half_bit_en (half_bit_en),
        .tx_eop_idle (tx_eop_idle),
        .rx_sop      (rx_sop),
        .resp_seen   (resp_seen),
        .timeout     (timeout),
        .budget_miss (budget_miss),
        .gap         (gap)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // Drive one cycle on the falling edge; check registered outputs after the rising edge.
    task automatic cyc(input bit tx, input bit sop, input bit tk,
                       input bit e_resp, input bit e_to, input bit e_bm,
                       input string req);
        @(negedge clk);
        tx_eop_idle = tx;
        rx_sop      = sop;
        half_bit_en = tk;
        @(posedge clk);
        #1;
        check(req, "resp_seen",   int'(resp_seen),   int'(e_resp));
        check(req, "timeout",     int'(timeout),     int'(e_to));
        check(req, "budget_miss", int'(budget_miss), int'(e_bm));
        check(req, "gap",         int'(gap),         exp_gap);
    endtask

    // Model-driven step: expectations from the bench's own count.
    task automatic step(input bit tx, input bit sop, input bit tk, input string req);
        bit r = 0, t = 0, b = 0;
        if (tx) begin
            m_armed = 1; m_cnt = 0; exp_gap = 0;
        end else if (m_armed && sop) begin
            r = 1; m_armed = 0; exp_gap = m_cnt;
        end else if (m_armed && tk) begin
            if (m_cnt == LIMIT) begin
                t = 1; m_armed = 0;
            end else begin
                b = (m_cnt == BUDGET);
                m_cnt++;
            end
        end
        cyc(tx, sop, tk, r, t, b, req);
    endtask

    initial begin
        #(20 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        if (!done) begin
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks + 1);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) cyc(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R1");
        @(negedge clk);
        rst = 1'b0;
        cyc(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R1");

        // R5: reply with monitor idle
        step(1'b0, 1'b1, 1'b0, "R5");

        // Sweep of tick counts, back to back and spaced
        for (int sp = 0; sp < 2; sp++) begin
            for (int n = 0; n <= 34; n++) begin
                string rq;
                rq = (n > LIMIT) ? "R4" : (n > BUDGET) ? "R7" : (n > 16) ? "R3" : "R2";
                if (n > 16 && n <= LIMIT && sp == 1) rq = "R3";
                step(1'b1, 1'b0, 1'b0, "R2");
                for (int i = 0; i < n; i++) begin
                    if (sp == 1) step(1'b0, 1'b0, 1'b0, "R2");
                    step(1'b0, 1'b0, 1'b1, rq);
                end
                step(1'b0, 1'b1, 1'b0, (n > LIMIT) ? "R5" : rq);
                step(1'b0, 1'b0, 1'b1, "R8");
                step(1'b0, 1'b0, 1'b0, "R8");
            end
        end

        // R6: restart while armed
        step(1'b1, 1'b0, 1'b0, "R6");
        for (int i = 0; i < 5; i++) step(1'b0, 1'b0, 1'b1, "R6");
        step(1'b1, 1'b0, 1'b0, "R6");
        for (int i = 0; i < 2; i++) step(1'b0, 1'b0, 1'b1, "R6");
        step(1'b0, 1'b1, 1'b0, "R6");
        check("R6", "gap after restart", int'(gap), 2);

        // R9: arm and reply in the same cycle
        step(1'b1, 1'b0, 1'b0, "R9");
        step(1'b1, 1'b1, 1'b0, "R9");
        for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 1'b1, "R9");
        step(1'b0, 1'b1, 1'b0, "R9");
        check("R9", "gap", int'(gap), 3);

        // R10: reply coincides with the tick that would expire the limit
        step(1'b1, 1'b0, 1'b0, "R10");
        for (int i = 0; i < LIMIT; i++) step(1'b0, 1'b0, 1'b1, "R10");
        step(1'b0, 1'b1, 1'b1, "R10");
        check("R10", "gap", int'(gap), LIMIT);

        // R10: coincident reply below the limit takes the current count
        step(1'b1, 1'b0, 1'b0, "R10");
        for (int i = 0; i < 4; i++) step(1'b0, 1'b0, 1'b1, "R10");
        step(1'b0, 1'b1, 1'b1, "R10");
        check("R10", "gap", int'(gap), 4);

        // R1: reset in the middle of an armed wait
        step(1'b1, 1'b0, 1'b0, "R1");
        step(1'b0, 1'b0, 1'b1, "R1");
        @(negedge clk);
        rst = 1'b1;
        m_armed = 0; m_cnt = 0; exp_gap = 0;
        cyc(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R1");
        @(negedge clk);
        rst = 1'b0;
        step(1'b0, 1'b1, 1'b0, "R1");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule